// File: doc/BRIEF.md
# ECC Syndrome to DIMM Pin Locator

This block turns a corrected-memory-error report into the identity of the failing memory module and, for a single-bit error, the connector pin that carries the failing bit. A request carries three things: a signed syndrome code, the physical address of the faulty access, and the local bank index reported by the bank decoder. The low bit of the bank index picks one of two groups of four modules. The result comes out two clock edges later, marked by a one-cycle done strobe.

For a single-bit error, the syndrome code is first remapped into bus bit order. The block then works out where that bit sits in a 576-bit cache-line transfer. The line moves as four beats of 144 bits, and the beat is chosen by the address line offset. The block uses that position to look up two tables held in local storage: a packed module map of 144 bytes (four 2-bit fields per byte) and a 576-entry pin map. A syndrome code of -1 marks a multi-bit error, and the block then returns a mask that names all four modules of the group. Codes outside -1..144 are rejected. Both tables are loaded through a byte-wide write port. A request presented in a cycle in which a table write is active is dropped.

Top module: `syn_pin_locator`

## Requirements
- R1: After reset, rpt_done, rpt_err and rpt_multi are low and rpt_module, rpt_pin and rpt_mask are zero. Outside a done cycle, rpt_err, rpt_multi and rpt_mask stay at zero.
- R2: A syndrome code below -1 or above 144 completes with rpt_done and rpt_err high, rpt_multi low, and rpt_module, rpt_pin and rpt_mask all zero.
- R3: Syndrome code -1 completes with rpt_multi high and rpt_err low. rpt_mask has four bits set: bits [3:0] (0x0F) when bank bit 0 is 0, and bits [7:4] (0xF0) when it is 1. rpt_module and rpt_pin are zero.
- R4: A code c from 0 to 144 is remapped before use. Codes below 128 become c+16. Codes 128..143 become c-137. Codes 144..146 become c-143. Higher codes become c-147.
- R5: The beat is address bits [5:4]. The in-line bit position L is (3-beat)*144 plus the remapped code.
- R6: If L is negative (beat 3 with codes 128..136), the request completes with rpt_err high and all other result fields zero.
- R7: With table position P = 575-L, the module select is bit 2*(3-(P mod 4)) of module-map byte P/4. This is the low bit of the 2-bit field in that byte, where field 0 sits in bits [7:6].
- R8: For a single-bit error, rpt_module = (bank bit 0)*4 + module select, and rpt_mask is zero.
- R9: For a single-bit error, rpt_pin equals pin-map entry L, not entry P.
- R10: An accepted request gives exactly one rpt_done pulse, in the cycle after the second rising edge following acceptance. Requests in consecutive cycles complete in consecutive cycles.
- R11: A request presented while tbl_wr_en is high is ignored, and no rpt_done follows it.
- R12: With tbl_wr_en high, tbl_wr_sel=0 writes module-map byte tbl_wr_addr (0..143) and tbl_wr_sel=1 writes pin-map entry tbl_wr_addr (0..575). The new value is used by every request accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_sel | input | 1 | 0 = module map, 1 = pin map |
| tbl_wr_addr | input | 10 | Table entry index |
| tbl_wr_data | input | 8 | Byte written |
| req_valid | input | 1 | Lookup request |
| req_syndrome | input | 10 | Signed syndrome code |
| req_addr | input | 16 | Physical address of the error (low bits) |
| req_bank | input | 2 | Local bank index from the bank decoder |
| rpt_done | output | 1 | Result strobe |
| rpt_err | output | 1 | Request rejected |
| rpt_multi | output | 1 | Multi-bit error result |
| rpt_module | output | 3 | Failing module index |
| rpt_pin | output | 8 | Failing connector pin |
| rpt_mask | output | 8 | Modules named by a multi-bit error |

## Verification
The assertions check the following on every cycle:
- the done pulse follows the first pipeline stage by exactly one edge, and no stage-one entry appears after a request that collided with a table write;
- error and multi-bit results are mutually exclusive;
- a multi-bit mask always names exactly four modules;
- a single-bit module index stays inside the requesting group;
- outputs stay quiet outside done cycles.

Only the bench scenarios can show that the arithmetic is right, because it depends on table contents. The bench compares results against its own copy of the tables to cover the remapping ranges, the beat-dependent bit position, the reversed packed-field lookup against the unreversed pin lookup, the negative-position rejection, and the point at which a table rewrite takes effect.

// File: rtl/loc_pkg.sv
package loc_pkg;
  // Cache-line geometry of one transfer.
  localparam int LINE_BEATS     = 4;
  localparam int BEAT_BITS      = 144;
  localparam int LINE_BITS      = LINE_BEATS * BEAT_BITS;
  localparam int FIELDS_PER_BYTE = 4;
  localparam int MAP_BYTES      = LINE_BITS / FIELDS_PER_BYTE;
  localparam int MODS_PER_GROUP = 4;
  localparam int MSEL_W         = $clog2(MODS_PER_GROUP);
  localparam int BEAT_W         = $clog2(LINE_BEATS);
  localparam int BEAT_LSB       = 4;   // 16 data bytes per beat
  localparam int PIN_IDX_W      = $clog2(LINE_BITS);
  localparam int MAP_IDX_W      = $clog2(MAP_BYTES);
  localparam int CW             = 12;  // internal signed arithmetic width

  localparam logic signed [CW-1:0] MAX_CODE   = 12'sd144;
  localparam logic signed [CW-1:0] MULTI_CODE = -12'sd1;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_MULTI  = 2'd1,
    KIND_BAD    = 2'd2
  } lookup_kind_e;

  // Move a syndrome code into bus bit order.
  function automatic logic signed [CW-1:0] remap_code(input logic signed [CW-1:0] c);
    if (c < 12'sd128)      return c + 12'sd16;
    else if (c < 12'sd144) return c - 12'sd137;
    else if (c < 12'sd147) return c - 12'sd143;
    else                   return c - 12'sd147;
  endfunction

  // Bit position inside the whole line; the last beat is at the low end.
  function automatic logic signed [CW-1:0] line_bit(input logic [BEAT_W-1:0] beat,
                                                   input logic signed [CW-1:0] rem);
    logic signed [CW-1:0] rev;
    rev = $signed({{(CW-BEAT_W){1'b0}}, ~beat});
    return rev * 12'sd144 + rem;
  endfunction

  // Low bit of the 2-bit field picked by off, field 0 in the top bits.
  function automatic logic field_low_bit(input logic [7:0] b, input logic [1:0] off);
    return b[{~off, 1'b0}];
  endfunction
endpackage

// File: rtl/loc_tables.sv
module loc_tables
  import loc_pkg::*;
#(
  parameter int TBL_AW = 10
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [TBL_AW-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [MAP_IDX_W-1:0] map_idx,
  input  logic [PIN_IDX_W-1:0] pin_idx,
  output logic [7:0]           map_byte,
  output logic [7:0]           pin_byte
);
  logic [7:0] mod_map [MAP_BYTES];
  logic [7:0] pin_map [LINE_BITS];

  logic map_hit, pin_hit;
  assign map_hit = wr_en && !wr_sel && (wr_addr < TBL_AW'(MAP_BYTES));
  assign pin_hit = wr_en &&  wr_sel && (wr_addr < TBL_AW'(LINE_BITS));

  always_ff @(posedge clk) begin
    if (map_hit) mod_map[wr_addr[MAP_IDX_W-1:0]] <= wr_data;
    if (pin_hit) pin_map[wr_addr[PIN_IDX_W-1:0]] <= wr_data;
  end

  assign map_byte = mod_map[map_idx];
  assign pin_byte = pin_map[pin_idx];
endmodule

// File: rtl/loc_decode.sv
module loc_decode
  import loc_pkg::*;
#(
  parameter int SYN_W = 10,
  parameter int GRP_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [SYN_W-1:0]     syndrome,
  input  logic [BEAT_W-1:0]    beat,
  input  logic [GRP_W-1:0]     group,
  output logic                 s1_valid,
  output lookup_kind_e         s1_kind,
  output logic [GRP_W-1:0]     s1_group,
  output logic [PIN_IDX_W-1:0] s1_line_pos,
  output logic [MAP_IDX_W-1:0] s1_map_idx,
  output logic [1:0]           s1_off
);
  logic signed [CW-1:0] code, rem, lpos, tpos;
  lookup_kind_e         kind;
  logic                 unused_tpos;

  always_comb begin
    code = $signed({{(CW-SYN_W){syndrome[SYN_W-1]}}, syndrome});
    rem  = remap_code(code);
    lpos = line_bit(beat, rem);
    tpos = 12'(LINE_BITS - 1) - lpos;
    if (code < MULTI_CODE || code > MAX_CODE) kind = KIND_BAD;
    else if (code == MULTI_CODE)              kind = KIND_MULTI;
    else if (lpos < 12'sd0)                   kind = KIND_BAD;
    else                                      kind = KIND_SINGLE;
  end

  assign unused_tpos = ^tpos[CW-1:PIN_IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_kind     <= KIND_BAD;
      s1_group    <= '0;
      s1_line_pos <= '0;
      s1_map_idx  <= '0;
      s1_off      <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_kind     <= kind;
        s1_group    <= group;
        s1_line_pos <= (kind == KIND_SINGLE) ? lpos[PIN_IDX_W-1:0] : '0;
        s1_map_idx  <= (kind == KIND_SINGLE) ? tpos[PIN_IDX_W-1:2] : '0;
        s1_off      <= (kind == KIND_SINGLE) ? tpos[1:0] : '0;
      end
    end
  end
endmodule

// File: rtl/loc_report.sv
module loc_report
  import loc_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int GRP_W      = 1,
  parameter int MOD_W      = GRP_W + MSEL_W,
  parameter int MASK_W     = NUM_GROUPS * MODS_PER_GROUP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s1_valid,
  input  lookup_kind_e       s1_kind,
  input  logic [GRP_W-1:0]   s1_group,
  input  logic [1:0]         s1_off,
  input  logic [7:0]         map_byte,
  input  logic [7:0]         pin_byte,
  output logic               rpt_done,
  output logic               rpt_err,
  output logic               rpt_multi,
  output logic [MOD_W-1:0]   rpt_module,
  output logic [7:0]         rpt_pin,
  output logic [MASK_W-1:0]  rpt_mask
);
  logic              is_single, is_multi, is_bad, sel;
  logic [MASK_W-1:0] mask_c;

  assign is_single = s1_valid && (s1_kind == KIND_SINGLE);
  assign is_multi  = s1_valid && (s1_kind == KIND_MULTI);
  assign is_bad    = s1_valid && (s1_kind == KIND_BAD);
  assign sel       = field_low_bit(map_byte, s1_off);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    assign mask_c[g*MODS_PER_GROUP +: MODS_PER_GROUP] =
      {MODS_PER_GROUP{is_multi && (s1_group == GRP_W'(g))}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_done   <= 1'b0;
      rpt_err    <= 1'b0;
      rpt_multi  <= 1'b0;
      rpt_module <= '0;
      rpt_pin    <= '0;
      rpt_mask   <= '0;
    end else begin
      rpt_done   <= s1_valid;
      rpt_err    <= is_bad;
      rpt_multi  <= is_multi;
      rpt_mask   <= mask_c;
      rpt_module <= is_single ? {s1_group, MSEL_W'(sel)} : '0;
      rpt_pin    <= is_single ? pin_byte : '0;
    end
  end
endmodule

// File: rtl/syn_pin_locator.sv
module syn_pin_locator
  import loc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_W     = 2,
  parameter int NUM_GROUPS = 2,
  parameter int SYN_W      = 10,
  parameter int TBL_AW     = 10,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int MOD_W     = GRP_W + MSEL_W,
  localparam int MASK_W    = NUM_GROUPS * MODS_PER_GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic              tbl_wr_sel,
  input  logic [TBL_AW-1:0] tbl_wr_addr,
  input  logic [7:0]        tbl_wr_data,
  input  logic              req_valid,
  input  logic [SYN_W-1:0]  req_syndrome,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_bank,
  output logic              rpt_done,
  output logic              rpt_err,
  output logic              rpt_multi,
  output logic [MOD_W-1:0]  rpt_module,
  output logic [7:0]        rpt_pin,
  output logic [MASK_W-1:0] rpt_mask
);
  // Named internal events for the checker.
  logic                 accept;
  logic                 s1_valid;
  lookup_kind_e         s1_kind;
  logic [GRP_W-1:0]     s1_group;
  logic [PIN_IDX_W-1:0] s1_line_pos;
  logic [MAP_IDX_W-1:0] s1_map_idx;
  logic [1:0]           s1_off;
  logic [7:0]           map_byte, pin_byte;
  logic                 unused_req_bits;

  assign accept          = req_valid && !tbl_wr_en;
  assign unused_req_bits = ^{req_addr, req_bank};

  loc_decode #(.SYN_W(SYN_W), .GRP_W(GRP_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .syndrome   (req_syndrome),
    .beat       (req_addr[BEAT_LSB +: BEAT_W]),
    .group      (req_bank[GRP_W-1:0]),
    .s1_valid   (s1_valid),
    .s1_kind    (s1_kind),
    .s1_group   (s1_group),
    .s1_line_pos(s1_line_pos),
    .s1_map_idx (s1_map_idx),
    .s1_off     (s1_off)
  );

  loc_tables #(.TBL_AW(TBL_AW)) u_tables (
    .clk     (clk),
    .wr_en   (tbl_wr_en),
    .wr_sel  (tbl_wr_sel),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .map_idx (s1_map_idx),
    .pin_idx (s1_line_pos),
    .map_byte(map_byte),
    .pin_byte(pin_byte)
  );

  loc_report #(
    .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .MOD_W(MOD_W), .MASK_W(MASK_W)
  ) u_report (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_kind   (s1_kind),
    .s1_group  (s1_group),
    .s1_off    (s1_off),
    .map_byte  (map_byte),
    .pin_byte  (pin_byte),
    .rpt_done  (rpt_done),
    .rpt_err   (rpt_err),
    .rpt_multi (rpt_multi),
    .rpt_module(rpt_module),
    .rpt_pin   (rpt_pin),
    .rpt_mask  (rpt_mask)
  );
endmodule

// File: rtl/loc_checker.sv
module loc_checker #(
  parameter int GRP_W  = 1,
  parameter int MOD_W  = 3,
  parameter int MASK_W = 8,
  parameter int MODS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              tbl_wr_en,
  input logic              s1_valid,
  input logic [GRP_W-1:0]  s1_group,
  input logic              rpt_done,
  input logic              rpt_err,
  input logic              rpt_multi,
  input logic [MOD_W-1:0]  rpt_module,
  input logic [7:0]        rpt_pin,
  input logic [MASK_W-1:0] rpt_mask
);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> rpt_done);

  p_done_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_done |-> $past(s1_valid));

  p_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tbl_wr_en) |=> !s1_valid);

  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_done |-> !(rpt_err && rpt_multi));

  p_err_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_done && rpt_err) |-> (rpt_mask == '0 && rpt_pin == '0 && rpt_module == '0));

  p_mask_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_done && rpt_multi) |-> ($countones(rpt_mask) == MODS));

  p_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_done && !rpt_multi && !rpt_err) |->
      (rpt_module[MOD_W-1 -: GRP_W] == $past(s1_group) && rpt_mask == '0));

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_done |-> (!rpt_err && !rpt_multi && rpt_mask == '0));
endmodule

bind syn_pin_locator loc_checker #(
  .GRP_W(GRP_W), .MOD_W(MOD_W), .MASK_W(MASK_W), .MODS(loc_pkg::MODS_PER_GROUP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .tbl_wr_en (tbl_wr_en),
  .s1_valid  (s1_valid),
  .s1_group  (s1_group),
  .rpt_done  (rpt_done),
  .rpt_err   (rpt_err),
  .rpt_multi (rpt_multi),
  .rpt_module(rpt_module),
  .rpt_pin   (rpt_pin),
  .rpt_mask  (rpt_mask)
);

// File: tb/tb_syn_pin_locator.sv
module tb_syn_pin_locator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_wr_en = 1'b0, tbl_wr_sel = 1'b0;
  logic [9:0] tbl_wr_addr = '0;
  logic [7:0] tbl_wr_data = '0;
  logic       req_valid = 1'b0;
  logic [9:0] req_syndrome = '0;
  logic [15:0] req_addr = '0;
  logic [1:0] req_bank = '0;
  logic       rpt_done, rpt_err, rpt_multi;
  logic [2:0] rpt_module;
  logic [7:0] rpt_pin, rpt_mask;

  int checks = 0, fails = 0;
  byte unsigned bmod [144];
  byte unsigned bpin [576];

  always #4 clk = ~clk;  // 125 MHz

  syn_pin_locator dut (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements.
  task automatic model(input int code, input int addr, input int bank,
                       output bit e_err, output bit e_multi,
                       output int e_mod, output int e_pin, output int e_mask);
    int rem, beat, lp, tp, fld;
    e_err = 0; e_multi = 0; e_mod = 0; e_pin = 0; e_mask = 0;
    if (code < -1 || code > 144) begin e_err = 1; return; end
    if (code == -1) begin
      e_multi = 1;
      e_mask = (bank % 2 == 1) ? 'hF0 : 'h0F;
      return;
    end
    if (code >= 147)      rem = code - 147;
    else if (code >= 144) rem = code - 143;
    else if (code >= 128) rem = code - 137;
    else                  rem = code + 16;
    beat = (addr / 16) % 4;
    lp = 144 * (3 - beat) + rem;
    if (lp < 0) begin e_err = 1; return; end
    tp = 575 - lp;
    fld = (bmod[tp / 4] >> (6 - 2 * (tp % 4))) % 4;
    e_mod = 4 * (bank % 2) + (fld % 2);
    e_pin = bpin[lp];
  endtask

  task automatic compare(int code, int addr, int bank, string req);
    bit e_err, e_multi; int e_mod, e_pin, e_mask;
    model(code, addr, bank, e_err, e_multi, e_mod, e_pin, e_mask);
    chk(rpt_done == 1'b1, "R10", "done", int'(rpt_done), 1);
    chk(rpt_err == e_err, req, "err", int'(rpt_err), int'(e_err));
    chk(rpt_multi == e_multi, req, "multi", int'(rpt_multi), int'(e_multi));
    chk(int'(rpt_mask) == e_mask, req, "mask", int'(rpt_mask), e_mask);
    chk(int'(rpt_module) == e_mod, req, "module", int'(rpt_module), e_mod);
    chk(int'(rpt_pin) == e_pin, req, "pin", int'(rpt_pin), e_pin);
  endtask

  task automatic drive_req(int code, int addr, int bank);
    req_valid = 1'b1;
    req_syndrome = 10'(code);
    req_addr = 16'(addr);
    req_bank = 2'(bank);
  endtask

  task automatic lookup(int code, int addr, int bank, string req);
    @(negedge clk); drive_req(code, addr, bank);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); compare(code, addr, bank, req);
  endtask

  task automatic write_tbl(bit sel, int addr, int data);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_sel = sel;
    tbl_wr_addr = 10'(addr); tbl_wr_data = 8'(data);
    if (sel) bpin[addr] = byte'(data); else bmod[addr] = byte'(data);
    @(negedge clk); tbl_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_set;
    seed_set = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rpt_done == 0 && rpt_err == 0 && rpt_multi == 0, "R1", "flags",
        int'({rpt_done, rpt_err, rpt_multi}), 0);
    chk(rpt_module == 0 && rpt_pin == 0 && rpt_mask == 0, "R1", "fields",
        int'({rpt_module, rpt_pin, rpt_mask}), 0);
    rst_n = 1'b1;

    // R12: load both tables
    for (int i = 0; i < 144; i++) write_tbl(1'b0, i, int'($urandom_range(0, 255)));
    for (int i = 0; i < 576; i++) write_tbl(1'b1, i, int'($urandom_range(0, 255)));

    // R3: multi-bit in each group
    lookup(-1, 'h00, 0, "R3");
    lookup(-1, 'h20, 3, "R3");
    lookup(-1, 'h10, 2, "R3");
    // R2: out of range codes
    lookup(-2, 'h00, 1, "R2");
    lookup(145, 'h30, 0, "R2");
    lookup(-300, 'h10, 0, "R2");
    // R4 R5: range edges and beats
    lookup(144, 'h00, 0, "R4");
    lookup(144, 'h30, 1, "R4");
    lookup(143, 'h30, 1, "R4");
    lookup(128, 'h20, 0, "R4");
    lookup(0, 'h20, 1, "R5");
    lookup(127, 'h00, 0, "R7");
    // R6: negative in-line position
    lookup(128, 'h30, 0, "R6");
    lookup(136, 'h3F, 1, "R6");
    // R9: position 0 on the pin map, byte 143 on the module map
    lookup(137, 'h30, 1, "R9");

    // R10: back-to-back requests and a single pulse
    @(negedge clk); drive_req(5, 'h10, 1);
    @(negedge clk); drive_req(-1, 'h00, 0);
    @(negedge clk); req_valid = 1'b0; compare(5, 'h10, 1, "R8");
    @(negedge clk); compare(-1, 'h00, 0, "R3");
    @(negedge clk);
    chk(rpt_done == 0, "R10", "single pulse", int'(rpt_done), 0);

    // R11: request during a table write is dropped
    @(negedge clk);
    drive_req(10, 'h00, 0);
    tbl_wr_en = 1'b1; tbl_wr_sel = 1'b1; tbl_wr_addr = 10'd26; tbl_wr_data = 8'hA5;
    bpin[26] = 8'hA5;
    @(negedge clk); req_valid = 1'b0; tbl_wr_en = 1'b0;
    chk(rpt_done == 0, "R11", "done one edge", int'(rpt_done), 0);
    @(negedge clk);
    chk(rpt_done == 0, "R11", "done two edges", int'(rpt_done), 0);
    // R12: the written entry is used (code 10, beat 3 -> position 26)
    lookup(10, 'h30, 0, "R12");
    write_tbl(1'b0, 137, 'h55);
    lookup(10, 'h30, 1, "R12");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int code, addr, bank;
      code = int'($urandom_range(0, 151)) - 3;
      addr = int'($urandom_range(0, 65535));
      bank = int'($urandom_range(0, 3));
      lookup(code, addr, bank, (code == -1) ? "R3" : "R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule